// File: doc/BRIEF.md
# One-Way Word Cache Controller with Selectable Write Policy

This block sits between a processor request port and a main-memory port and keeps a small set of recently used words in a direct-mapped store. Each slot holds one word, a valid flag, a dirty flag and a tag. The low address bits choose the slot, and the remaining high bits form the tag that is compared to decide hit or miss. A load miss fetches the word from memory and installs it. A store miss installs the new word directly, because a slot holds one word and no fetch is needed.

A mode input chooses the store policy while the controller is idle. In write-through mode each store also goes to memory, and the cached copy stays clean. In write-back mode stores stay in the cache and mark the slot dirty. Any miss whose slot holds a valid dirty word first writes that word back, and this holds in either mode, so no modified data is lost when the mode changes. Four counters classify every completed request as a load hit, load miss, store hit or store miss.

The processor holds its request fields steady until `cpu_ready` is high for one cycle. That cycle completes the request. The memory port uses a request/acknowledge pair.

Top module: `dmc_cache`

## Requirements
- R1: After reset every slot is invalid, all four counters read zero, and `cpu_ready` and `mem_req` are low while no request is present, so the first access to any slot misses.
- R2: The slot index is the address modulo the slot count (the low address bits) and the stored tag is the address divided by the slot count. With 8 slots, a load-only trace 0,1,3,6,9,13,14,3,18,19,13 hits exactly on the second 3 and the second 13.
- R3: A load hit completes in the cycle it is presented: `cpu_ready` is high in that cycle, `cpu_rdata` carries the cached word, and there is no memory traffic.
- R4: A load miss issues a memory read (`mem_we`=0) at the request address. It completes in the acknowledge cycle with `cpu_rdata` equal to `mem_rdata` and installs the word, so that a repeated load hits.
- R5: `mem_req` stays high, with address, write flag and write data stable, until `mem_ack`. `cpu_ready` stays low while a memory transfer is outstanding.
- R6: With `wb_mode`=0, every store writes its word to memory at its address and completes in the acknowledge cycle. The cached copy is written as well, and is allocated on a miss, so a following load of that address hits.
- R7: With `wb_mode`=1, a store hit, or a store miss whose slot is not dirty, completes in its first cycle without memory traffic, and the slot becomes dirty.
- R8: A miss whose slot holds a valid dirty word first writes that word to memory at the address formed from the old tag and the index, whatever the mode. A clean or invalid slot is replaced with no memory write.
- R9: Each completed request increments exactly one of the counters `cnt_load_hit`, `cnt_load_miss`, `cnt_store_hit` or `cnt_store_miss`. The class is decided by the lookup when the request is first presented.
- R10: A slot that was written back and then refilled by a load is clean, so replacing it again causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through; change only while idle |
| cpu_req | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DW | Load data, valid when `cpu_ready` is high for a load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the transfer in this cycle |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| cnt_load_hit | output | CW | Completed load hits |
| cnt_load_miss | output | CW | Completed load misses |
| cnt_store_hit | output | CW | Completed store hits |
| cnt_store_miss | output | CW | Completed store misses |

## Verification
A load-only address trace with colliding indices shows whether the index/tag split is right. A wrong split moves or adds hits, and a missing valid reset adds early hits. A write-back sequence stores into a slot and then evicts it twice: once dirty, once clean. This separates dirty-gated eviction from unconditional eviction, and a correct eviction address from a wrong one. Write-through stores on a miss and on a hit show whether memory is updated every time and whether the line is allocated. A dirty line left by write-back mode and then replaced in write-through mode shows whether eviction depends on the dirty flag or on the current mode.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } dmc_state_e;

  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned EVT_LH  = 0;
  localparam int unsigned EVT_LM  = 1;
  localparam int unsigned EVT_SH  = 2;
  localparam int unsigned EVT_SM  = 3;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned TW    = 5,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic          rd_dirty,
  output logic [TW-1:0] rd_tag,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic          wr_dirty,
  input  logic [TW-1:0] wr_tag
);

  logic [NSLOT-1:0] valid_q;
  logic [NSLOT-1:0] dirty_q;
  logic [TW-1:0]    tag_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        dirty_q[s] <= 1'b0;
      end else if (sel) begin
        valid_q[s] <= wr_valid;
        dirty_q[s] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[s] <= wr_tag;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] word_q [NSLOT];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx] <= wr_data;
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/dmc_evt_counters.sv
module dmc_evt_counters #(
  parameter int unsigned NUM = 4,
  parameter int unsigned CW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NUM-1:0] evt,
  output logic [CW-1:0]  count [NUM]
);

  for (genvar k = 0; k < NUM; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      count[k] <= '0;
      else if (evt[k]) count[k] <= count[k] + CW'(1);
    end
  end

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned NSLOT = 8,
  parameter int unsigned CW    = 16,
  localparam int unsigned IW   = $clog2(NSLOT),
  localparam int unsigned TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_mode,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] cnt_load_hit,
  output logic [CW-1:0] cnt_load_miss,
  output logic [CW-1:0] cnt_store_hit,
  output logic [CW-1:0] cnt_store_miss
);

  // Address arithmetic kept in functions.
  function automatic logic [IW-1:0] slot_of(input logic [AW-1:0] a);
    return a[IW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [TW-1:0] t, input logic [IW-1:0] s);
    return {t, s};
  endfunction

  dmc_state_e state_q, state_d;
  logic       missed_q;

  logic [IW-1:0] req_idx;
  logic [TW-1:0] req_tag;
  logic          lk_valid, lk_dirty;
  logic [TW-1:0] lk_tag;
  logic [DW-1:0] lk_data;

  logic          tw_en, tw_valid, tw_dirty;
  logic          dw_en;
  logic [DW-1:0] dw_data;

  // Named internal events for the checker.
  logic          lookup_hit;
  logic          victim_dirty;
  logic          evict_start;
  logic          req_done;
  logic          done_is_miss;
  logic          ev_lh, ev_lm, ev_sh, ev_sm;
  logic [NUM_EVT-1:0] evt_vec;
  logic [CW-1:0]      cnt_arr [NUM_EVT];

  assign req_idx = slot_of(cpu_addr);
  assign req_tag = tag_of(cpu_addr);

  dmc_tag_store #(.NSLOT(NSLOT), .TW(TW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (lk_valid),
    .rd_dirty (lk_dirty),
    .rd_tag   (lk_tag),
    .wr_en    (tw_en),
    .wr_idx   (req_idx),
    .wr_valid (tw_valid),
    .wr_dirty (tw_dirty),
    .wr_tag   (req_tag)
  );

  dmc_data_store #(.NSLOT(NSLOT), .DW(DW)) u_data (
    .clk     (clk),
    .rd_idx  (req_idx),
    .rd_data (lk_data),
    .wr_en   (dw_en),
    .wr_idx  (req_idx),
    .wr_data (dw_data)
  );

  assign lookup_hit   = lk_valid && (lk_tag == req_tag);
  assign victim_dirty = lk_valid && lk_dirty;

  always_comb begin
    state_d     = state_q;
    cpu_ready   = 1'b0;
    cpu_rdata   = lk_data;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cpu_addr;
    mem_wdata   = cpu_wdata;
    tw_en       = 1'b0;
    tw_valid    = 1'b1;
    tw_dirty    = 1'b0;
    dw_en       = 1'b0;
    dw_data     = cpu_wdata;
    evict_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (lookup_hit) begin
            if (!cpu_we) begin
              cpu_ready = 1'b1;
            end else if (wb_mode) begin
              cpu_ready = 1'b1;
              dw_en     = 1'b1;
              tw_en     = 1'b1;
              tw_dirty  = 1'b1;
            end else begin
              state_d = ST_WTHRU;
            end
          end else if (victim_dirty) begin
            evict_start = 1'b1;
            state_d     = ST_EVICT;
          end else if (!cpu_we) begin
            state_d = ST_FILL;
          end else if (wb_mode) begin
            cpu_ready = 1'b1;
            dw_en     = 1'b1;
            tw_en     = 1'b1;
            tw_dirty  = 1'b1;
          end else begin
            state_d = ST_WTHRU;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = join_addr(lk_tag, req_idx);
        mem_wdata = lk_data;
        if (mem_ack) begin
          tw_en    = 1'b1;
          tw_valid = 1'b0;
          state_d  = ST_IDLE;
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          cpu_rdata = mem_rdata;
          dw_en     = 1'b1;
          dw_data   = mem_rdata;
          tw_en     = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          dw_en     = 1'b1;
          tw_en     = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Remember that the request was classified as a miss when first seen.
  always_ff @(posedge clk) begin
    if (!rst_n)                                              missed_q <= 1'b0;
    else if (req_done)                                       missed_q <= 1'b0;
    else if (state_q == ST_IDLE && cpu_req && !lookup_hit)   missed_q <= 1'b1;
  end

  assign req_done     = cpu_req && cpu_ready;
  assign done_is_miss = missed_q || !lookup_hit;
  assign ev_lh = req_done && !cpu_we && !done_is_miss;
  assign ev_lm = req_done && !cpu_we &&  done_is_miss;
  assign ev_sh = req_done &&  cpu_we && !done_is_miss;
  assign ev_sm = req_done &&  cpu_we &&  done_is_miss;

  always_comb begin
    evt_vec         = '0;
    evt_vec[EVT_LH] = ev_lh;
    evt_vec[EVT_LM] = ev_lm;
    evt_vec[EVT_SH] = ev_sh;
    evt_vec[EVT_SM] = ev_sm;
  end

  dmc_evt_counters #(.NUM(NUM_EVT), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_vec),
    .count (cnt_arr)
  );

  assign cnt_load_hit   = cnt_arr[EVT_LH];
  assign cnt_load_miss  = cnt_arr[EVT_LM];
  assign cnt_store_hit  = cnt_arr[EVT_SH];
  assign cnt_store_miss = cnt_arr[EVT_SM];

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_mode,
  input logic          cpu_req,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          evict_start,
  input logic          ev_lh,
  input logic          ev_lm,
  input logic          ev_sh,
  input logic          ev_sm
);

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |-> !cpu_ready);

  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_lh, ev_lm, ev_sh, ev_sm}));

  a_r9_event_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready |-> $countones({ev_lh, ev_lm, ev_sh, ev_sm}) == 1);

  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lh |-> !mem_req);

  a_r7_wb_store_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    wb_mode && ev_sh |-> !mem_req);

  a_r6_wt_store_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_mode && (ev_sh || ev_sm) |-> mem_req && mem_we && mem_ack);

  a_r8_evict_writes: assert property (@(posedge clk) disable iff (!rst_n)
    evict_start |=> mem_req && mem_we);

endmodule

bind dmc_cache dmc_cache_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wb_mode     (wb_mode),
  .cpu_req     (cpu_req),
  .cpu_ready   (cpu_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .evict_start (evict_start),
  .ev_lh       (ev_lh),
  .ev_lm       (ev_lm),
  .ev_sh       (ev_sh),
  .ev_sm       (ev_sm)
);

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_cache_tb;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NSLOT = 8;
  localparam int CW = 16;
  localparam int NTR = 11;

  // Trace table: address and expected hit flag (R2).
  localparam logic [AW-1:0] TR_ADDR [NTR] = '{8'd0, 8'd1, 8'd3, 8'd6, 8'd9, 8'd13, 8'd14, 8'd3, 8'd18, 8'd19, 8'd13};
  localparam logic          TR_HIT  [NTR] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wb_mode;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] c_lh, c_lm, c_sh, c_sm;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] bmem [1 << AW];
  int            wr_cnt;
  int            rd_cnt;
  logic [AW-1:0] last_wr;
  int            wcnt;

  always #10 clk = ~clk;

  dmc_cache #(.AW(AW), .DW(DW), .NSLOT(NSLOT), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_load_hit(c_lh), .cnt_load_miss(c_lm), .cnt_store_hit(c_sh), .cnt_store_miss(c_sm)
  );

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 3 + 7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model driven from an initial block at the falling edge.
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        wcnt++;
        if (wcnt >= 2) begin
          wcnt = 0;
          if (mem_we) begin
            bmem[mem_addr] = mem_wdata;
            wr_cnt++;
            last_wr = mem_addr;
          end else begin
            mem_rdata = bmem[mem_addr];
            rd_cnt++;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic do_reset(input logic mode);
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    wb_mode = mode;
    rst_n = 1'b0;
    for (int i = 0; i < (1 << AW); i++) bmem[i] = init_word(i);
    wr_cnt = 0; rd_cnt = 0; last_wr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int cyc);
    bit done;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0; done = 0;
    while (!done) begin
      #5;
      if (cpu_ready) done = 1;
      else if (cyc > 2000) begin
        done = 1;
        chk("R5 request never completed", 32'(cyc), 32'd0);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int cyc, w0, r0;
    logic [CW-1:0] h0;

    // R1: reset state
    do_reset(1'b0);
    @(negedge clk); #5;
    chk("R1 cpu_ready idle", 32'(cpu_ready), 32'd0);
    chk("R1 mem_req idle", 32'(mem_req), 32'd0);
    chk("R1 counters zero", 32'(c_lh) + 32'(c_lm) + 32'(c_sh) + 32'(c_sm), 32'd0);

    // R2/R3/R4: trace table walk
    for (int i = 0; i < NTR; i++) begin
      h0 = c_lh; r0 = rd_cnt;
      access(1'b0, TR_ADDR[i], '0, rd, cyc);
      #2;
      chk("R2 hit pattern", 32'(c_lh - h0), 32'(TR_HIT[i]));
      chk("R4 load data", rd, init_word(int'(TR_ADDR[i])));
      if (TR_HIT[i]) begin
        chk("R3 hit same cycle", 32'(cyc), 32'd0);
        chk("R3 hit no memory read", 32'(rd_cnt - r0), 32'd0);
      end
    end
    chk("R2 load hits total", 32'(c_lh), 32'd2);
    chk("R2 load misses total", 32'(c_lm), 32'd9);
    chk("R1 first access misses", 32'(c_lm) + 32'(c_lh), 32'd11);

    // Write-back sequence (R7, R8, R10, R9)
    do_reset(1'b1);
    access(1'b1, 8'd5, 32'hA5A5_0001, rd, cyc);
    chk("R7 wb store miss one cycle", 32'(cyc), 32'd0);
    chk("R7 wb store no memory write", 32'(wr_cnt), 32'd0);
    access(1'b0, 8'd5, '0, rd, cyc);
    chk("R3 load hit after wb store", rd, 32'hA5A5_0001);
    chk("R7 memory untouched by wb store", bmem[5], init_word(5));
    access(1'b0, 8'd13, '0, rd, cyc);
    chk("R8 dirty eviction count", 32'(wr_cnt), 32'd1);
    chk("R8 eviction address", 32'(last_wr), 32'd5);
    chk("R8 evicted data", bmem[5], 32'hA5A5_0001);
    chk("R4 fill data after eviction", rd, init_word(13));
    w0 = wr_cnt;
    access(1'b0, 8'd21, '0, rd, cyc);
    chk("R10 clean replacement no write", 32'(wr_cnt - w0), 32'd0);
    chk("R4 fill data", rd, init_word(21));
    access(1'b1, 8'd21, 32'h0BAD_F00D, rd, cyc);
    chk("R7 wb store hit one cycle", 32'(cyc), 32'd0);
    access(1'b1, 8'd29, 32'h1111_2222, rd, cyc);
    chk("R8 store miss evicts dirty", 32'(wr_cnt - w0), 32'd1);
    chk("R8 store eviction data", bmem[21], 32'h0BAD_F00D);
    chk("R9 load hits", 32'(c_lh), 32'd1);
    chk("R9 load misses", 32'(c_lm), 32'd2);
    chk("R9 store hits", 32'(c_sh), 32'd1);
    chk("R9 store misses", 32'(c_sm), 32'd2);

    // Write-through sequence (R6)
    do_reset(1'b0);
    access(1'b1, 8'd2, 32'h0000_1234, rd, cyc);
    chk("R6 wt store miss writes memory", bmem[2], 32'h0000_1234);
    chk("R6 wt write count", 32'(wr_cnt), 32'd1);
    access(1'b0, 8'd2, '0, rd, cyc);
    chk("R6 allocate then hit", 32'(cyc), 32'd0);
    chk("R6 cached value", rd, 32'h0000_1234);
    access(1'b1, 8'd2, 32'h0000_5678, rd, cyc);
    chk("R6 wt store hit writes memory", bmem[2], 32'h0000_5678);
    chk("R9 wt store hit counted", 32'(c_sh), 32'd1);
    w0 = wr_cnt;
    access(1'b0, 8'd10, '0, rd, cyc);
    chk("R8 clean wt line no eviction", 32'(wr_cnt - w0), 32'd0);

    // Dirty line survives a mode change (R8)
    @(negedge clk); wb_mode = 1'b1;
    access(1'b1, 8'd10, 32'hCAFE_0010, rd, cyc);
    @(negedge clk); wb_mode = 1'b0;
    w0 = wr_cnt;
    access(1'b0, 8'd18, '0, rd, cyc);
    chk("R8 dirty evicted in wt mode", 32'(wr_cnt - w0), 32'd1);
    chk("R8 dirty data preserved", bmem[10], 32'hCAFE_0010);
    chk("R4 fill after mode change", rd, init_word(18));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule